// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a 32-bit processor that completes one instruction in every clock cycle. Each cycle it fetches a word from its internal instruction array at the program counter, decodes it, runs the ALU, reads or writes the internal data array, and writes the result back to the register file. It handles thirteen instructions: seven register-register operations (add, addu, sub, and, or, slt, sltu) and six immediate, memory and control operations (addi, lui, lw, sw, beq, j).

Decoding is split across two small lookup decoders. The main decoder reads the opcode and drives a 2-bit ALU operation class. It uses only the classes 0, 1 and 2. The ALU decoder combines that class with the funct field to choose the ALU function.

The instruction array is filled through a write port while the core is held in reset. A separate debug read port returns any register's contents at any time without disturbing execution. A program's effects, including stores, are therefore observed through that port.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and every register reads 0 on the debug port. The first rising edge after release executes the word at address 0.
- R2: R-type instructions (opcode 0x00) use these funct codes: add 0x20, addu 0x21, sub 0x22, and 0x24, or 0x25. Each writes rs op rt to rd, wrapping modulo 2^32 with no trap on overflow. The main decoder never emits ALU class 3.
- R3: slt (funct 0x2A) writes 1 to rd if rs < rt as signed numbers, otherwise 0. sltu (funct 0x2B) makes the same test with unsigned numbers.
- R4: addi (opcode 0x08) writes rs plus the sign-extended 16-bit immediate to rt, with no trap.
- R5: lui (opcode 0x0F) writes the immediate to bits 31..16 of rt and clears bits 15..0.
- R6: sw (opcode 0x2B) stores rt to the word at rs plus the sign-extended offset. lw (opcode 0x23) loads that word into rt.
- R7: beq (opcode 0x04) sets the next PC to PC+4 + (sign-extended immediate << 2) when rs equals rt. Otherwise the next PC is PC+4. Every other non-jump instruction also advances the PC by 4.
- R8: j (opcode 0x02) sets the next PC to {PC+4[31:28], target26, 2'b00}.
- R9: Register 0 always reads 0. Writes to register 0 have no effect.
- R10: dbg_data_o shows the register selected by dbg_addr_i in the same cycle, independently of the operand ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_we_i | input | 1 | Instruction array write enable |
| imem_addr_i | input | $clog2(IMEM_DEPTH) (6) | Instruction word index to write |
| imem_wdata_i | input | 32 | Instruction word to write |
| dbg_addr_i | input | 5 | Debug register select |
| dbg_data_o | output | 32 | Contents of the selected register |
| pc_o | output | 32 | Current program counter |

## Verification
A wrong decode-table entry or a wrong ALU function writes a bad value into the destination register in the cycle that instruction executes. The debug port then shows the bad value from the next cycle until the register is overwritten. A wrong next-PC value shows on pc_o after one edge. It also shows later as registers that should have been skipped but were written, or that should have been written but were skipped. Each sweep program parks on a self-jump, so every result can be read out at rest once the program has finished.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned NREG = 32;
  localparam int unsigned RA   = $clog2(NREG);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  // ALU operation class from main decoder; 2'b11 is never produced
  localparam logic [1:0] AOP_ADD   = 2'b00;
  localparam logic [1:0] AOP_SUB   = 2'b01;
  localparam logic [1:0] AOP_FUNCT = 2'b10;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_SLTU
  } alu_fn_e;

  typedef struct packed {
    logic       dst_rd;
    logic       b_imm;
    logic       b_upper;
    logic       wb_mem;
    logic       reg_we;
    logic       mem_we;
    logic       is_beq;
    logic       is_jump;
    logic [1:0] aop;
  } ctrl_t;
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec import sc_core_pkg::*; (
  input  logic [5:0] opcode_i,
  output ctrl_t      ctrl_o
);
  // lookup table indexed by opcode
  always_comb begin
    ctrl_o = '0;
    unique case (opcode_i)
      OP_RTYPE: begin ctrl_o.dst_rd = 1'b1; ctrl_o.reg_we = 1'b1; ctrl_o.aop = AOP_FUNCT; end
      OP_ADDI:  begin ctrl_o.b_imm = 1'b1; ctrl_o.reg_we = 1'b1; ctrl_o.aop = AOP_ADD; end
      OP_LUI:   begin ctrl_o.b_imm = 1'b1; ctrl_o.b_upper = 1'b1; ctrl_o.reg_we = 1'b1; end
      OP_LW:    begin ctrl_o.b_imm = 1'b1; ctrl_o.wb_mem = 1'b1; ctrl_o.reg_we = 1'b1; end
      OP_SW:    begin ctrl_o.b_imm = 1'b1; ctrl_o.mem_we = 1'b1; end
      OP_BEQ:   begin ctrl_o.is_beq = 1'b1; ctrl_o.aop = AOP_SUB; end
      OP_J:     ctrl_o.is_jump = 1'b1;
      default:  ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec import sc_core_pkg::*; (
  input  logic [1:0] aop_i,
  input  logic [5:0] funct_i,
  output alu_fn_e    fn_o
);
  always_comb begin
    fn_o = ALU_ADD;
    case (aop_i)
      AOP_SUB:   fn_o = ALU_SUB;
      AOP_FUNCT: begin
        case (funct_i)
          FN_ADD, FN_ADDU: fn_o = ALU_ADD;
          FN_SUB:          fn_o = ALU_SUB;
          FN_AND:          fn_o = ALU_AND;
          FN_OR:           fn_o = ALU_OR;
          FN_SLT:          fn_o = ALU_SLT;
          FN_SLTU:         fn_o = ALU_SLTU;
          default:         fn_o = ALU_ADD;
        endcase
      end
      default:   fn_o = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu import sc_core_pkg::*; (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_fn_e         fn_i,
  output logic [XLEN-1:0] y_o,
  output logic            zero_o
);
  always_comb begin
    case (fn_i)
      ALU_SUB:  y_o = a_i - b_i;
      ALU_AND:  y_o = a_i & b_i;
      ALU_OR:   y_o = a_i | b_i;
      ALU_SLT:  y_o = {{(XLEN-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      ALU_SLTU: y_o = {{(XLEN-1){1'b0}}, a_i < b_i};
      default:  y_o = a_i + b_i;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile import sc_core_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RA-1:0]   ra_addr_i,
  output logic [XLEN-1:0] ra_data_o,
  input  logic [RA-1:0]   rb_addr_i,
  output logic [XLEN-1:0] rb_data_o,
  input  logic [RA-1:0]   dbg_addr_i,
  output logic [XLEN-1:0] dbg_data_o,
  input  logic            we_i,
  input  logic [RA-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign ra_data_o  = (ra_addr_i  == '0) ? '0 : regs_q[ra_addr_i];
  assign rb_data_o  = (rb_addr_i  == '0) ? '0 : regs_q[rb_addr_i];
  assign dbg_data_o = (dbg_addr_i == '0) ? '0 : regs_q[dbg_addr_i];

  // R9: a write to a nonzero register lands on the next edge; r0 stays zero
  p_write_lands_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0) |=> regs_q[$past(waddr_i)] == $past(wdata_i));
  p_r0_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q[0] == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core import sc_core_pkg::*; #(
  parameter  int unsigned IMEM_DEPTH = 64,
  parameter  int unsigned DMEM_DEPTH = 64,
  localparam int unsigned IA = $clog2(IMEM_DEPTH),
  localparam int unsigned DA = $clog2(DMEM_DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            imem_we_i,
  input  logic [IA-1:0]   imem_addr_i,
  input  logic [XLEN-1:0] imem_wdata_i,
  input  logic [RA-1:0]   dbg_addr_i,
  output logic [XLEN-1:0] dbg_data_o,
  output logic [XLEN-1:0] pc_o
);
  logic [XLEN-1:0] imem [IMEM_DEPTH];
  logic [XLEN-1:0] dmem [DMEM_DEPTH];
  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_tgt, jmp_tgt, instr;
  logic [XLEN-1:0] sext, op_a, op_b, rt_data, alu_y, dmem_rdata, wb_data;
  logic [RA-1:0]   waddr;
  logic            zero, take_br, unused_shamt;
  ctrl_t           ctrl;
  alu_fn_e         alu_fn;

  always_ff @(posedge clk_i) begin
    if (imem_we_i) imem[imem_addr_i] <= imem_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign instr = imem[pc_q[IA+1:2]];
  assign unused_shamt = ^instr[10:6];

  sc_main_dec i_main_dec (.opcode_i(instr[31:26]), .ctrl_o(ctrl));
  sc_alu_dec  i_alu_dec  (.aop_i(ctrl.aop), .funct_i(instr[5:0]), .fn_o(alu_fn));

  assign waddr = ctrl.dst_rd ? instr[15:11] : instr[20:16];

  sc_regfile i_regfile (
    .clk_i, .rst_ni,
    .ra_addr_i(instr[25:21]), .ra_data_o(op_a),
    .rb_addr_i(instr[20:16]), .rb_data_o(rt_data),
    .dbg_addr_i, .dbg_data_o,
    .we_i(ctrl.reg_we), .waddr_i(waddr), .wdata_i(wb_data)
  );

  assign sext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  // lui: upper-immediate operand added to rs, which is r0 in the encoding
  assign op_b = !ctrl.b_imm  ? rt_data :
                ctrl.b_upper ? {instr[15:0], 16'h0000} : sext;

  sc_alu i_alu (.a_i(op_a), .b_i(op_b), .fn_i(alu_fn), .y_o(alu_y), .zero_o(zero));

  assign dmem_rdata = dmem[alu_y[DA+1:2]];
  always_ff @(posedge clk_i) begin
    if (rst_ni && ctrl.mem_we) dmem[alu_y[DA+1:2]] <= rt_data;
  end

  assign wb_data = ctrl.wb_mem ? dmem_rdata : alu_y;

  // shift-left-2 of offsets is wiring only
  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = pc_plus4 + {sext[XLEN-3:0], 2'b00};
  assign jmp_tgt  = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign take_br  = ctrl.is_beq && zero;
  assign pc_d     = ctrl.is_jump ? jmp_tgt : take_br ? br_tgt : pc_plus4;
  assign pc_o     = pc_q;

  p_aluop_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.aop != 2'b11);
  p_slt_bool_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_fn == ALU_SLT || alu_fn == ALU_SLTU) |-> alu_y[XLEN-1:1] == '0);
  p_pc_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.is_jump && !ctrl.is_beq) |=> pc_q == $past(pc_q) + 32'd4);
  p_beq_eq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.is_beq && op_a == rt_data) |=> pc_q == $past(br_tgt));
  p_beq_ne_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.is_beq && op_a != rt_data) |=> pc_q == $past(pc_plus4));
  p_jump_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.is_jump |=> pc_q == {$past(pc_plus4[31:28]), $past(instr[25:0]), 2'b00});
endmodule

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
module test_sc_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        imem_we = 1'b0;
  logic [5:0]  imem_addr = '0;
  logic [31:0] imem_wdata = '0;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_data, pc;
  logic [31:0] prog [64];
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  sc_core i_sc_core (
    .clk_i(clk), .rst_ni(rst_ni), .imem_we_i(imem_we), .imem_addr_i(imem_addr),
    .imem_wdata_i(imem_wdata), .dbg_addr_i(dbg_addr), .dbg_data_o(dbg_data), .pc_o(pc)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(int idx);
    return {6'h02, 26'(idx)};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp, string what);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic chk_reg(string req, int r, logic [31:0] exp);
    dbg_addr = 5'(r);
    #1;
    chk(req, dbg_data, exp, $sformatf("r%0d", r));
  endtask

  task automatic load_run(int n, int cyc);
    rst_ni = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_addr = 6'(i); imem_wdata = prog[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
    rst_ni = 1'b1;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] vals [6];
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7fff_ffff;
    vals[3] = 32'h8000_0000; vals[4] = 32'hffff_ffff; vals[5] = 32'h1234_8765;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", pc, 32'h0, "pc in reset");
    chk_reg("R1", 5, 32'h0);
    chk_reg("R1", 31, 32'h0);

    // R2 R3 R4 R5 R7 sweep over operand pairs
    foreach (vals[ia]) begin
      foreach (vals[ib]) begin
        logic [31:0] a, b;
        logic [15:0] ha, hb;
        a = vals[ia]; b = vals[ib];
        ha = a[31:16] + {15'h0, a[15]};
        hb = b[31:16] + {15'h0, b[15]};
        prog[0]  = enc_i(6'h0F, 0, 1, ha);
        prog[1]  = enc_i(6'h08, 1, 1, a[15:0]);
        prog[2]  = enc_i(6'h0F, 0, 2, hb);
        prog[3]  = enc_i(6'h08, 2, 2, b[15:0]);
        prog[4]  = enc_r(1, 2, 3, 6'h20);
        prog[5]  = enc_r(1, 2, 4, 6'h21);
        prog[6]  = enc_r(1, 2, 5, 6'h22);
        prog[7]  = enc_r(1, 2, 6, 6'h24);
        prog[8]  = enc_r(1, 2, 7, 6'h25);
        prog[9]  = enc_r(1, 2, 8, 6'h2A);
        prog[10] = enc_r(1, 2, 9, 6'h2B);
        prog[11] = enc_i(6'h04, 1, 2, 16'h0001);
        prog[12] = enc_i(6'h08, 0, 10, 16'h0001);
        prog[13] = enc_i(6'h08, 0, 11, 16'h0002);
        prog[14] = enc_j(14);
        load_run(15, 17);
        chk_reg("R4", 1, a);
        chk_reg("R5", 2, b);
        chk_reg("R2", 3, a + b);
        chk_reg("R2", 4, a + b);
        chk_reg("R2", 5, a - b);
        chk_reg("R2", 6, a & b);
        chk_reg("R2", 7, a | b);
        chk_reg("R3", 8, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        chk_reg("R3", 9, (a < b) ? 32'd1 : 32'd0);
        chk_reg("R7", 10, (a == b) ? 32'd0 : 32'd1);
        chk_reg("R7", 11, 32'd2);
        chk("R8", pc, 32'd56, "pc parked");
      end
    end

    // R6 store and load with positive and negative offsets
    prog[0] = enc_i(6'h08, 0, 5, 16'd16);
    prog[1] = enc_i(6'h0F, 0, 1, 16'hABCD);
    prog[2] = enc_i(6'h08, 1, 1, 16'h0055);
    prog[3] = enc_i(6'h2B, 5, 1, 16'h0008);
    prog[4] = enc_i(6'h2B, 5, 5, 16'hFFFC);
    prog[5] = enc_i(6'h23, 5, 2, 16'h0008);
    prog[6] = enc_i(6'h23, 5, 3, 16'hFFFC);
    prog[7] = enc_r(2, 3, 4, 6'h20);
    prog[8] = enc_j(8);
    load_run(9, 11);
    chk_reg("R6", 2, 32'hABCD_0055);
    chk_reg("R6", 3, 32'd16);
    chk_reg("R6", 4, 32'hABCD_0065);

    // R9 R4 R5 R10: zero register, negative immediates, debug port
    prog[0] = enc_i(6'h08, 0, 0, 16'd5);
    prog[1] = enc_r(0, 0, 6, 6'h20);
    prog[2] = enc_i(6'h08, 0, 7, 16'hFFFF);
    prog[3] = enc_i(6'h0F, 0, 12, 16'h8001);
    prog[4] = enc_i(6'h08, 0, 31, 16'h07FF);
    prog[5] = enc_i(6'h08, 7, 13, 16'h8000);
    prog[6] = enc_j(6);
    load_run(7, 9);
    chk_reg("R9", 0, 32'h0);
    chk_reg("R9", 6, 32'h0);
    chk_reg("R4", 7, 32'hFFFF_FFFF);
    chk_reg("R5", 12, 32'h8001_0000);
    chk_reg("R4", 13, 32'hFFFF_7FFF);
    chk_reg("R10", 31, 32'h0000_07FF);
    chk_reg("R10", 12, 32'h8001_0000);
    chk("R10", pc, 32'd24, "pc unaffected by debug reads");

    // R7 backward branch loop
    prog[0] = enc_i(6'h08, 0, 1, 16'd0);
    prog[1] = enc_i(6'h08, 0, 2, 16'd5);
    prog[2] = enc_i(6'h08, 1, 1, 16'd1);
    prog[3] = enc_i(6'h04, 1, 2, 16'h0001);
    prog[4] = enc_i(6'h04, 0, 0, 16'hFFFD);
    prog[5] = enc_j(5);
    load_run(6, 40);
    chk_reg("R7", 1, 32'd5);
    chk("R7", pc, 32'd20, "pc after loop");

    // R8 forward jump skips two words; R1 first edge runs word 0
    prog[0] = enc_j(3);
    prog[1] = enc_i(6'h08, 0, 1, 16'd1);
    prog[2] = enc_i(6'h08, 0, 2, 16'd2);
    prog[3] = enc_i(6'h08, 0, 3, 16'd3);
    prog[4] = enc_j(4);
    load_run(5, 1);
    chk("R1", pc, 32'd12, "pc after first edge");
    repeat (3) @(negedge clk);
    chk_reg("R8", 1, 32'd0);
    chk_reg("R8", 2, 32'd0);
    chk_reg("R8", 3, 32'd3);
    chk("R8", pc, 32'd16, "pc parked");

    summary();
  end
endmodule